// File: doc/BRIEF.md
# Register Stack Frame Allocator

This block keeps track of the stacked register frames that a procedure sees as logical registers r32 and above. A frame has a local part followed by an output part, and it lives in a circular pool of physical registers. The block moves the frame base around that pool. When a procedure is called, the caller's output registers become the callee's first registers. When the callee returns, the caller's full frame comes back. The block also translates a logical register number into a physical pool index, so the register array next to it can be addressed directly.

The pool can only hold so many registers. When a larger frame would not fit beside the registers still held for older frames, the block asks for the oldest registers to be written out and stalls until that transfer is acknowledged. When a return needs a caller's locals that were written out earlier, it asks for them to be read back and stalls in the same way. The memory transfers and the register array are outside the block. It reports only how many registers to move.

A small stack inside the block keeps each suspended caller's base, local count and frame size. Requests that cannot be honoured are refused with a one-cycle error pulse, and the state is left unchanged.

Top module: `regframe_alloc`

## Requirements
- R1: After reset the frame size is 0, `busy`, `op_err`, `spill_req` and `fill_req` are low, and every translation reports `xlat_err`.
- R2: An accepted request with `op_code` 2'b01 (allocate) and `op_locals`+`op_outs` ≤ 96 makes the frame size that sum and keeps the frame base. A larger sum is refused: `op_err` is high for the one cycle after the accepting edge, and the frame is unchanged.
- R3: For `lreg` from 32 to 31+frame size, `preg` = (base + `lreg` − 32) mod POOL, combinationally. Any other `lreg`, including values below 32, raises `xlat_err`.
- R4: An accepted request with `op_code` 2'b10 (call) moves the base forward by the caller's local count, modulo POOL. The new frame size is the caller's output count. As a result, caller logical register 32+locals+k and callee register 32+k map to the same physical index.
- R5: An accepted request with `op_code` 2'b11 (return) restores the caller's base and frame size. A return while no caller is saved is refused with `op_err`, and the frame is unchanged.
- R6: At most DEPTH callers can be saved. A call when DEPTH are already saved is refused with `op_err`, and the frame is unchanged.
- R7: If an allocate would make the held registers (older frames' resident locals plus the new frame) exceed POOL, then `spill_req` rises with `spill_cnt` equal to the excess. `busy` stays high until `spill_ack`, and the new frame takes effect at the acknowledging edge.
- R8: A return whose caller has fewer locals resident than its local count raises `fill_req` with `fill_cnt` equal to the missing count. `busy` stays high until `fill_ack`, and the caller's frame takes effect at the acknowledging edge.
- R9: Requests presented while `busy` is high are ignored.
- R10: `spill_req` and `fill_req` are never high together, and a pending request keeps its count stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Request present |
| op_code | input | 2 | 01 allocate, 10 call, 11 return, 00 none |
| op_locals | input | 7 | Local count for allocate |
| op_outs | input | 7 | Output count for allocate |
| busy | output | 1 | Waiting for a transfer acknowledge; requests ignored |
| op_err | output | 1 | One-cycle pulse for a refused request |
| spill_req | output | 1 | Write-out of oldest registers requested |
| spill_cnt | output | 7 | Registers to write out |
| spill_ack | input | 1 | Write-out done |
| fill_req | output | 1 | Read-back of caller registers requested |
| fill_cnt | output | 7 | Registers to read back |
| fill_ack | input | 1 | Read-back done |
| lreg | input | 7 | Logical register to translate |
| preg | output | $clog2(POOL) | Physical pool index |
| xlat_err | output | 1 | `lreg` is outside the current frame |
| frame_size | output | 7 | Current frame size |

## Verification
The bench walks a nest of three calls in which frames pass the end of the pool. If the base were not reduced modulo POOL, translations near r127 would point past the pool. The bench forces two spills of different sizes, then unwinds through returns that need partial and full read-backs. A design that counted the resident registers wrongly would give the wrong spill or fill count, or would skip a request. It also sends a call while a spill is pending, which a design without the busy gate would apply. It also fills the marker stack and makes both underflow and oversize-allocate refusals, where a faulty design would corrupt the frame instead of leaving it unchanged.

// File: rtl/regframe_pkg.sv
package regframe_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_ALLOC = 2'b01,
    OP_CALL  = 2'b10,
    OP_RET   = 2'b11
  } rf_op_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'b00,
    ST_SPILL = 2'b01,
    ST_FILL  = 2'b10
  } rf_state_e;

  localparam int MAX_FRAME = 96;
  localparam int FW        = 7;
endpackage

// File: rtl/regframe_mstack.sv
module regframe_mstack #(
  parameter int DEPTH = 4,
  parameter int W     = 21
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] top_i;

  assign full  = (cnt_q == PW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign top_i = cnt_q - PW'(1);
  assign dout  = slot[top_i[IW-1:0]];

  always_comb begin
    cnt_d = cnt_q;
    if (push && !full)       cnt_d = cnt_q + PW'(1);
    else if (pop && !empty)  cnt_d = cnt_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (push && !full) slot[cnt_q[IW-1:0]] <= din;
  end
endmodule

// File: rtl/regframe_xlat.sv
module regframe_xlat #(
  parameter int POOL = 128,
  parameter int PBW  = 7,
  parameter int FW   = 7
) (
  input  logic [PBW-1:0] base,
  input  logic [FW-1:0]  sof,
  input  logic [6:0]     lreg,
  output logic [PBW-1:0] preg,
  output logic           err
);
  localparam logic [PBW:0] POOL_W = (PBW+1)'(POOL);

  logic [6:0]   off;
  logic [PBW:0] sum;
  logic         in_frame;

  assign off      = lreg - 7'd32;
  assign in_frame = (lreg >= 7'd32) && ({1'b0, off} < {1'b0, sof});
  assign sum      = (PBW+1)'(base) + (PBW+1)'(off);
  assign preg     = (sum >= POOL_W) ? PBW'(sum - POOL_W) : PBW'(sum);
  assign err      = !in_frame;
endmodule

// File: rtl/regframe_alloc.sv
module regframe_alloc #(
  parameter int POOL  = 128,
  parameter int DEPTH = 4,
  localparam int PBW  = $clog2(POOL)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [1:0]     op_code,
  input  logic [6:0]     op_locals,
  input  logic [6:0]     op_outs,
  output logic           busy,
  output logic           op_err,
  output logic           spill_req,
  output logic [6:0]     spill_cnt,
  input  logic           spill_ack,
  output logic           fill_req,
  output logic [6:0]     fill_cnt,
  input  logic           fill_ack,
  input  logic [6:0]     lreg,
  output logic [PBW-1:0] preg,
  output logic           xlat_err,
  output logic [6:0]     frame_size
);
  import regframe_pkg::*;

  localparam int CW = $clog2(POOL + 1);
  localparam int MW = PBW + 2 * FW;
  localparam logic [PBW:0] POOL_B = (PBW+1)'(POOL);
  localparam logic [CW:0]  POOL_C = (CW+1)'(POOL);

  rf_state_e      state_q, state_d;
  logic [PBW-1:0] base_q, base_d, pbase_q, pbase_d;
  logic [FW-1:0]  sol_q, sol_d, psol_q, psol_d;
  logic [FW-1:0]  sof_q, sof_d, psof_q, psof_d;
  logic [CW-1:0]  below_q, below_d, pbelow_q, pbelow_d;
  logic [FW-1:0]  cnt_q, cnt_d;
  logic           err_q, err_d;

  logic           push, pop, st_full, st_empty;
  logic [MW-1:0]  mk_in, mk_out;
  logic [PBW-1:0] c_base;
  logic [FW-1:0]  c_sol, c_sof;
  logic [7:0]     tot;
  logic [CW:0]    need;
  logic [PBW:0]   bsum;
  rf_op_e         op;

  assign op    = rf_op_e'(op_code);
  assign mk_in = {base_q, sol_q, sof_q};
  assign {c_base, c_sol, c_sof} = mk_out;
  assign tot   = {1'b0, op_locals} + {1'b0, op_outs};
  assign need  = (CW+1)'(below_q) + (CW+1)'(tot);
  assign bsum  = (PBW+1)'(base_q) + (PBW+1)'(sol_q);

  regframe_mstack #(.DEPTH(DEPTH), .W(MW)) u_mstack (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .din(mk_in), .dout(mk_out), .full(st_full), .empty(st_empty)
  );

  regframe_xlat #(.POOL(POOL), .PBW(PBW), .FW(FW)) u_xlat (
    .base(base_q), .sof(sof_q), .lreg(lreg), .preg(preg), .err(xlat_err)
  );

  always_comb begin
    state_d  = state_q;
    base_d   = base_q;   sol_d  = sol_q;  sof_d  = sof_q;  below_d  = below_q;
    pbase_d  = pbase_q;  psol_d = psol_q; psof_d = psof_q; pbelow_d = pbelow_q;
    cnt_d    = cnt_q;
    err_d    = 1'b0;
    push     = 1'b0;
    pop      = 1'b0;
    unique case (state_q)
      ST_RUN: if (op_valid) begin
        unique case (op)
          OP_ALLOC: begin
            if (tot > 8'(MAX_FRAME)) begin
              err_d = 1'b1;
            end else if (need > POOL_C) begin
              pbase_d  = base_q;
              psol_d   = op_locals;
              psof_d   = FW'(tot);
              cnt_d    = FW'(need - POOL_C);
              pbelow_d = CW'(POOL_C - (CW+1)'(tot));
              state_d  = ST_SPILL;
            end else begin
              sol_d = op_locals;
              sof_d = FW'(tot);
            end
          end
          OP_CALL: begin
            if (st_full) begin
              err_d = 1'b1;
            end else begin
              push    = 1'b1;
              base_d  = (bsum >= POOL_B) ? PBW'(bsum - POOL_B) : PBW'(bsum);
              below_d = below_q + CW'(sol_q);
              sof_d   = sof_q - sol_q;
              sol_d   = '0;
            end
          end
          OP_RET: begin
            if (st_empty) begin
              err_d = 1'b1;
            end else begin
              pop = 1'b1;
              if (below_q >= CW'(c_sol)) begin
                base_d  = c_base;
                sol_d   = c_sol;
                sof_d   = c_sof;
                below_d = below_q - CW'(c_sol);
              end else begin
                pbase_d  = c_base;
                psol_d   = c_sol;
                psof_d   = c_sof;
                pbelow_d = '0;
                cnt_d    = c_sol - FW'(below_q);
                state_d  = ST_FILL;
              end
            end
          end
          default: ;
        endcase
      end
      ST_SPILL, ST_FILL: begin
        if ((state_q == ST_SPILL && spill_ack) || (state_q == ST_FILL && fill_ack)) begin
          base_d  = pbase_q;
          sol_d   = psol_q;
          sof_d   = psof_q;
          below_d = pbelow_q;
          state_d = ST_RUN;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      base_q   <= '0;
      sol_q    <= '0;
      sof_q    <= '0;
      below_q  <= '0;
      pbase_q  <= '0;
      psol_q   <= '0;
      psof_q   <= '0;
      pbelow_q <= '0;
      cnt_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      base_q   <= base_d;
      sol_q    <= sol_d;
      sof_q    <= sof_d;
      below_q  <= below_d;
      pbase_q  <= pbase_d;
      psol_q   <= psol_d;
      psof_q   <= psof_d;
      pbelow_q <= pbelow_d;
      cnt_q    <= cnt_d;
      err_q    <= err_d;
    end
  end

  assign busy       = (state_q != ST_RUN);
  assign op_err     = err_q;
  assign spill_req  = (state_q == ST_SPILL);
  assign fill_req   = (state_q == ST_FILL);
  assign spill_cnt  = spill_req ? cnt_q : '0;
  assign fill_cnt   = fill_req  ? cnt_q : '0;
  assign frame_size = sof_q;
endmodule

// File: rtl/regframe_alloc_chk.sv
module regframe_alloc_chk #(
  parameter int POOL = 128,
  localparam int PBW = $clog2(POOL)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           op_err,
  input logic           spill_req,
  input logic [6:0]     spill_cnt,
  input logic           spill_ack,
  input logic           fill_req,
  input logic [6:0]     fill_cnt,
  input logic           fill_ack,
  input logic [6:0]     lreg,
  input logic [PBW-1:0] preg,
  input logic           xlat_err,
  input logic [6:0]     frame_size
);
  // R10
  no_dual_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({spill_req, fill_req}));

  // R10
  spill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spill_req && !spill_ack) |=> (spill_req && $stable(spill_cnt)));

  // R10
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !fill_ack) |=> (fill_req && $stable(fill_cnt)));

  // R7
  spill_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spill_req |-> (spill_cnt != 7'd0 && busy));

  // R8
  fill_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> (fill_cnt != 7'd0 && busy));

  // R3
  static_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lreg < 7'd32) |-> xlat_err);

  // R3
  pool_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xlat_err |-> (int'(preg) < POOL));

  // R2
  frame_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_size <= 7'd96);

  // R2
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |-> $stable(frame_size));
endmodule

bind regframe_alloc regframe_alloc_chk #(.POOL(POOL)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .op_err(op_err),
  .spill_req(spill_req), .spill_cnt(spill_cnt), .spill_ack(spill_ack),
  .fill_req(fill_req), .fill_cnt(fill_cnt), .fill_ack(fill_ack),
  .lreg(lreg), .preg(preg), .xlat_err(xlat_err), .frame_size(frame_size)
);

// File: tb/regframe_alloc_test.sv
module regframe_alloc_test;
  localparam int POOL  = 128;
  localparam int DEPTH = 4;
  localparam int PBW   = $clog2(POOL);

  logic           clk, rst_n;
  logic           op_valid;
  logic [1:0]     op_code;
  logic [6:0]     op_locals, op_outs;
  logic           busy, op_err;
  logic           spill_req, fill_req, spill_ack, fill_ack;
  logic [6:0]     spill_cnt, fill_cnt;
  logic [6:0]     lreg;
  logic [PBW-1:0] preg;
  logic           xlat_err;
  logic [6:0]     frame_size;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  regframe_alloc #(.POOL(POOL), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_locals(op_locals), .op_outs(op_outs), .busy(busy), .op_err(op_err),
    .spill_req(spill_req), .spill_cnt(spill_cnt), .spill_ack(spill_ack),
    .fill_req(fill_req), .fill_cnt(fill_cnt), .fill_ack(fill_ack),
    .lreg(lreg), .preg(preg), .xlat_err(xlat_err), .frame_size(frame_size)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [1:0] op;
    logic [6:0] l;
    logic [6:0] o;
    logic [6:0] sp;
    logic [6:0] fl;
    logic       er;
    logic [6:0] sof;
    logic [6:0] probe;
    logic [6:0] pexp;
    logic       perr;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{2'b01, 7'd10, 7'd6,  7'd0,  7'd0,  1'b0, 7'd16, 7'd47,  7'd15, 1'b0},
    '{2'b10, 7'd0,  7'd0,  7'd0,  7'd0,  1'b0, 7'd6,  7'd32,  7'd10, 1'b0},
    '{2'b01, 7'd40, 7'd8,  7'd0,  7'd0,  1'b0, 7'd48, 7'd80,  7'd0,  1'b1},
    '{2'b10, 7'd0,  7'd0,  7'd0,  7'd0,  1'b0, 7'd8,  7'd39,  7'd57, 1'b0},
    '{2'b01, 7'd90, 7'd6,  7'd18, 7'd0,  1'b0, 7'd96, 7'd127, 7'd17, 1'b0},
    '{2'b10, 7'd0,  7'd0,  7'd0,  7'd0,  1'b0, 7'd6,  7'd37,  7'd17, 1'b0},
    '{2'b01, 7'd50, 7'd20, 7'd64, 7'd0,  1'b0, 7'd70, 7'd101, 7'd81, 1'b0},
    '{2'b11, 7'd0,  7'd0,  7'd0,  7'd32, 1'b0, 7'd96, 7'd32,  7'd50, 1'b0},
    '{2'b11, 7'd0,  7'd0,  7'd0,  7'd40, 1'b0, 7'd48, 7'd79,  7'd57, 1'b0},
    '{2'b11, 7'd0,  7'd0,  7'd0,  7'd10, 1'b0, 7'd16, 7'd47,  7'd15, 1'b0},
    '{2'b11, 7'd0,  7'd0,  7'd0,  7'd0,  1'b1, 7'd16, 7'd48,  7'd0,  1'b1},
    '{2'b01, 7'd60, 7'd37, 7'd0,  7'd0,  1'b1, 7'd16, 7'd31,  7'd0,  1'b1},
    '{2'b01, 7'd0,  7'd96, 7'd0,  7'd0,  1'b0, 7'd96, 7'd127, 7'd95, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [6:0] l, input logic [6:0] o);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; op_locals = l; op_outs = o;
    @(negedge clk);
    op_valid = 1'b0; op_code = 2'b00;
  endtask

  task automatic ack_spill();
    spill_ack = 1'b1;
    @(negedge clk);
    spill_ack = 1'b0;
  endtask

  task automatic ack_fill();
    fill_ack = 1'b1;
    @(negedge clk);
    fill_ack = 1'b0;
  endtask

  task automatic probe(input logic [6:0] r, input logic [6:0] exp, input string tag);
    lreg = r;
    #1;
    chk(!xlat_err && preg == PBW'(exp), tag, int'(preg), int'(exp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = 2'b00; op_locals = '0; op_outs = '0;
    spill_ack = 1'b0; fill_ack = 1'b0; lreg = 7'd32;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(frame_size == 7'd0, "R1 frame_size", int'(frame_size), 0);
    chk({busy, op_err, spill_req, fill_req} == 4'b0, "R1 flags", int'({busy, op_err, spill_req, fill_req}), 0);
    chk(xlat_err == 1'b1, "R1 xlat_err", int'(xlat_err), 1);

    // R2 R3 R4 R5 R7 R8: vector walk
    for (int i = 0; i < NV; i++) begin
      issue(TBL[i].op, TBL[i].l, TBL[i].o);
      chk(op_err == TBL[i].er, $sformatf("R2/R5 row %0d op_err", i), int'(op_err), int'(TBL[i].er));
      if (TBL[i].sp != 0) begin
        chk(spill_req && busy && spill_cnt == TBL[i].sp, $sformatf("R7 row %0d spill_cnt", i),
            int'(spill_cnt), int'(TBL[i].sp));
        ack_spill();
      end else if (TBL[i].fl != 0) begin
        chk(fill_req && busy && fill_cnt == TBL[i].fl, $sformatf("R8 row %0d fill_cnt", i),
            int'(fill_cnt), int'(TBL[i].fl));
        ack_fill();
      end else begin
        chk(!spill_req && !fill_req, $sformatf("R7/R8 row %0d no transfer", i),
            int'({spill_req, fill_req}), 0);
      end
      chk(frame_size == TBL[i].sof, $sformatf("R2/R4/R5 row %0d frame_size", i),
          int'(frame_size), int'(TBL[i].sof));
      lreg = TBL[i].probe;
      #1;
      if (TBL[i].perr)
        chk(xlat_err, $sformatf("R3 row %0d xlat_err", i), int'(xlat_err), 1);
      else
        chk(!xlat_err && preg == PBW'(TBL[i].pexp), $sformatf("R3/R4 row %0d preg", i),
            int'(preg), int'(TBL[i].pexp));
    end

    // R9: request during a pending spill is ignored
    issue(2'b01, 7'd40, 7'd56);
    issue(2'b10, 7'd0, 7'd0);
    probe(7'd32, 7'd40, "R4 call base");
    issue(2'b01, 7'd80, 7'd16);
    chk(spill_req && spill_cnt == 7'd8, "R7 spill_cnt 8", int'(spill_cnt), 8);
    issue(2'b10, 7'd0, 7'd0);
    chk(spill_req && busy && spill_cnt == 7'd8, "R9 still waiting", int'(spill_cnt), 8);
    ack_spill();
    chk(frame_size == 7'd96 && !busy, "R9 frame after ack", int'(frame_size), 96);
    probe(7'd32, 7'd40, "R9 base unchanged by ignored call");

    // R8: partial read-back
    issue(2'b11, 7'd0, 7'd0);
    chk(fill_req && busy && fill_cnt == 7'd8, "R8 fill_cnt 8", int'(fill_cnt), 8);
    ack_fill();
    chk(frame_size == 7'd96, "R5 caller size", int'(frame_size), 96);
    probe(7'd127, 7'd95, "R5 caller base");

    // R6: marker stack full
    for (int k = 0; k < DEPTH; k++) issue(2'b10, 7'd0, 7'd0);
    chk(frame_size == 7'd56 && !op_err, "R6 calls accepted", int'(frame_size), 56);
    issue(2'b10, 7'd0, 7'd0);
    chk(op_err == 1'b1, "R6 overflow err", int'(op_err), 1);
    chk(frame_size == 7'd56, "R6 frame unchanged", int'(frame_size), 56);
    probe(7'd32, 7'd40, "R6 base unchanged");
    for (int k = 0; k < DEPTH; k++) begin
      issue(2'b11, 7'd0, 7'd0);
      chk(!fill_req && !op_err, "R8 resident caller needs no fill", int'({fill_req, op_err}), 0);
    end
    chk(frame_size == 7'd96, "R5 outermost size", int'(frame_size), 96);
    probe(7'd127, 7'd95, "R5 outermost base");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule